// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up counter, four bits wide by default, that steps through the binary values and wraps from all-ones back to zero. Every change of state happens on the rising clock edge. That includes a clear and a preset, which are both synchronous and active low. Clear has priority over preset, preset has priority over counting, and holding is the fallback when nothing else applies.

Counting needs two enables. The first enable acts only on the stage it drives. The second enable also reaches the terminal-count output. Because of this, several instances can be chained into a wider counter with no glue logic. The terminal-count output of one stage feeds the chain enable of the next stage. A shared enable, or a lookahead term, drives the other enable of every stage.

The terminal-count output is combinational. It is high while the counter sits at its maximum value and the chain enable is high. The state is undefined after power-up until the first clear, so a system must apply a clear before it relies on the count.

Top module: `cascade_counter`

## Requirements
- R1: With `sync_clr_n` and `load_n` both high and both enables high, `count` increments by one on each rising edge, and the value after all-ones (15 for the default width) is 0.
- R2: When `sync_clr_n` is low (0), `count` becomes 0 after the next rising edge, whatever `load_n`, `data_in` and both enables are.
- R3: When `sync_clr_n` is high and `load_n` is low, `count` takes the value of `data_in` after the next rising edge, whatever the enables are.
- R4: When `sync_clr_n` and `load_n` are high, counting takes place only if `en_stage` and `en_chain` are both high.
- R5: When `sync_clr_n` and `load_n` are high and either enable is low, `count` keeps its value across the edge.
- R6: `term_cnt` is 1 exactly when `en_chain` is 1 and `count` is all-ones. It follows `en_chain` without waiting for a clock edge.
- R7: `en_stage` has no effect on `term_cnt`.
- R8: `count` changes only at a rising clock edge. Changes to the inputs between edges leave it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| sync_clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous preset, active low |
| data_in | input | WIDTH | Preset value |
| en_stage | input | 1 | Count enable local to this stage |
| en_chain | input | 1 | Count enable that also gates terminal count |
| count | output | WIDTH | Current counter state |
| term_cnt | output | 1 | High at the maximum value while `en_chain` is high |

## Verification
The bench goes through every combination of the four control inputs, starting from several preset states, and compares the result with a reference model. This catches any swap in precedence, for example a design that lets a preset beat a simultaneous clear and so loads the data instead of zeroing. Separate scenarios cover the following:
- the wrap from 15 to 0, where a design with a wrong carry would stick at 15 or jump to a wrong value;
- terminal count reacting to `en_chain` between clock edges, and not reacting to `en_stage` at all, where a registered or wrongly gated output would lag or follow the wrong enable;
- input changes between edges, which must not move the count before the next edge.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

   // Action taken at the next rising edge, listed by precedence.
   typedef enum logic [1:0] {
      MODE_CLEAR = 2'd0,
      MODE_LOAD  = 2'd1,
      MODE_COUNT = 2'd2,
      MODE_HOLD  = 2'd3
   } cnt_mode_e;

   // Increment structure variants.
   localparam int INC_ADDER  = 0;
   localparam int INC_TOGGLE = 1;

endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
   import cascade_counter_pkg::*;
(
   input  logic      clr_n,
   input  logic      ld_n,
   input  logic      en_a,
   input  logic      en_b,
   output cnt_mode_e mode
);

   // Fixed precedence: clear, then load, then count, then hold.
   always_comb begin
      if (!clr_n)            mode = MODE_CLEAR;
      else if (!ld_n)        mode = MODE_LOAD;
      else if (en_a && en_b) mode = MODE_COUNT;
      else                   mode = MODE_HOLD;
   end

endmodule

// File: rtl/cnt_incr.sv
module cnt_incr
   import cascade_counter_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter int INC_STYLE = INC_TOGGLE
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (INC_STYLE == INC_ADDER) begin : g_adder
         // Plain adder; the carry out of the top bit is dropped, so the value wraps.
         assign nxt = cur + ONE;
      end else begin : g_toggle
         // Bit i toggles when every lower bit is one.
         logic [WIDTH-1:0] carry;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lsb
               assign carry[i] = 1'b1;
            end else begin : g_up
               assign carry[i] = carry[i-1] & cur[i-1];
            end
            assign nxt[i] = cur[i] ^ carry[i];
         end
      end
   endgenerate

endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             chain_en,
   output logic             tc
);

   // Combinational: the output follows chain_en with no clock in the path.
   assign tc = chain_en & (&cur);

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
   import cascade_counter_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter int INC_STYLE = INC_TOGGLE
) (
   input  logic             clk,
   input  logic             sync_clr_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] data_in,
   input  logic             en_stage,
   input  logic             en_chain,
   output logic [WIDTH-1:0] count,
   output logic             term_cnt
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cascade_counter: WIDTH must be at least 1");
      end
      if (INC_STYLE != INC_ADDER && INC_STYLE != INC_TOGGLE) begin : g_bad_style
         $error("cascade_counter: INC_STYLE must select a known variant");
      end
   endgenerate

   cnt_mode_e        mode;
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] incr;

   cnt_mode_sel u_mode (
      .clr_n (sync_clr_n),
      .ld_n  (load_n),
      .en_a  (en_stage),
      .en_b  (en_chain),
      .mode  (mode)
   );

   cnt_incr #(
      .WIDTH     (WIDTH),
      .INC_STYLE (INC_STYLE)
   ) u_incr (
      .cur (state_q),
      .nxt (incr)
   );

   cnt_term #(
      .WIDTH (WIDTH)
   ) u_term (
      .cur      (state_q),
      .chain_en (en_chain),
      .tc       (term_cnt)
   );

   // No asynchronous reset: the state is undefined until the first clear.
   always_ff @(posedge clk) begin
      unique case (mode)
         MODE_CLEAR: state_q <= ZERO;
         MODE_LOAD:  state_q <= data_in;
         MODE_COUNT: state_q <= incr;
         default:    state_q <= state_q;
      endcase
   end

   assign count = state_q;

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             sync_clr_n,
   input logic             load_n,
   input logic [WIDTH-1:0] data_in,
   input logic             en_stage,
   input logic             en_chain,
   input logic [WIDTH-1:0] count,
   input logic             term_cnt
);

   localparam logic [WIDTH-1:0] ALL_ONES = '1;
   localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

   // The state is known only after the first clear has been taken.
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!sync_clr_n) armed <= 1'b1;
   end

   p_wrap_r1: assert property (@(posedge clk) disable iff (!armed)
      (sync_clr_n && load_n && en_stage && en_chain && count == ALL_ONES) |=> (count == '0));

   p_clear_r2: assert property (@(posedge clk) disable iff (!armed)
      (!sync_clr_n) |=> (count == '0));

   p_load_r3: assert property (@(posedge clk) disable iff (!armed)
      (sync_clr_n && !load_n) |=> (count == $past(data_in)));

   p_count_r4: assert property (@(posedge clk) disable iff (!armed)
      (sync_clr_n && load_n && en_stage && en_chain) |=> (count == $past(count) + ONE));

   p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
      (sync_clr_n && load_n && !(en_stage && en_chain)) |=> $stable(count));

   p_tc_r6: assert property (@(posedge clk) disable iff (!armed)
      term_cnt == (en_chain && count == ALL_ONES));

   p_tc_chain_r7: assert property (@(posedge clk) disable iff (!armed)
      (!en_chain) |-> !term_cnt);

endmodule

bind cascade_counter cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .sync_clr_n (sync_clr_n),
   .load_n     (load_n),
   .data_in    (data_in),
   .en_stage   (en_stage),
   .en_chain   (en_chain),
   .count      (count),
   .term_cnt   (term_cnt)
);

// File: tb/cascade_counter_test.sv
`timescale 1ns/1ps
module cascade_counter_test;

   localparam int W = 4;
   localparam logic [W-1:0] MAXV = '1;

   logic         clk = 1'b0;
   logic         sync_clr_n = 1'b1;
   logic         load_n = 1'b1;
   logic [W-1:0] data_in = '0;
   logic         en_stage = 1'b0;
   logic         en_chain = 1'b0;
   logic [W-1:0] count;
   logic         term_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   logic [W-1:0] exp_q;

   always #2 clk = ~clk;   // 250 MHz

   cascade_counter #(.WIDTH(W)) uut (
      .clk        (clk),
      .sync_clr_n (sync_clr_n),
      .load_n     (load_n),
      .data_in    (data_in),
      .en_stage   (en_stage),
      .en_chain   (en_chain),
      .count      (count),
      .term_cnt   (term_cnt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Inputs change 1 ns after an edge; results are sampled 1 ns after the next edge.
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic c, input logic l,
                                          input logic a, input logic b, input logic [W-1:0] d);
      if (!c)          return '0;
      else if (!l)     return d;
      else if (a && b) return cur + 1'b1;
      else             return cur;
   endfunction

   task automatic set_ctl(input logic c, input logic l, input logic a, input logic b,
                          input logic [W-1:0] d);
      sync_clr_n = c; load_n = l; en_stage = a; en_chain = b; data_in = d;
   endtask

   task automatic preset(input logic [W-1:0] v);
      set_ctl(1, 0, 0, 0, v);
      step();
      exp_q = v;
   endtask

   task automatic t_reset();
      set_ctl(0, 0, 1, 1, 4'd9);
      step();
      chk(count == 0, "R2 clear from power-up", count, 0);
      chk(term_cnt == 0, "R6 tc after clear", term_cnt, 0);
      exp_q = '0;
   endtask

   task automatic t_count_wrap();
      preset(4'd12);
      set_ctl(1, 1, 1, 1, 4'd0);
      for (int i = 0; i < 20; i++) begin
         step();
         exp_q = exp_q + 1'b1;
         chk(count == exp_q, "R1 count/wrap", count, exp_q);
      end
   endtask

   task automatic t_load();
      logic [W-1:0] vals [4] = '{4'd0, 4'd15, 4'd10, 4'd5};
      for (int i = 0; i < 4; i++) begin
         set_ctl(1, 0, i[0], i[1], vals[i]);
         step();
         chk(count == vals[i], "R3 load over enables", count, vals[i]);
      end
   endtask

   task automatic t_clear_over_load();
      preset(4'd7);
      set_ctl(0, 0, 1, 1, 4'd11);
      step();
      chk(count == 0, "R2 clear beats load", count, 0);
   endtask

   task automatic t_hold();
      preset(4'd6);
      set_ctl(1, 1, 1, 0, 4'd0);
      step();
      chk(count == 6, "R5 hold, chain low", count, 6);
      set_ctl(1, 1, 0, 1, 4'd0);
      step();
      chk(count == 6, "R5 hold, stage low", count, 6);
      set_ctl(1, 1, 1, 1, 4'd0);
      step();
      chk(count == 7, "R4 count with both high", count, 7);
   endtask

   task automatic t_term();
      preset(MAXV);
      set_ctl(1, 1, 0, 0, 4'd0);
      #1;
      chk(term_cnt == 0, "R6 tc low when chain low", term_cnt, 0);
      en_chain = 1;
      #0.5;
      chk(term_cnt == 1, "R6 tc follows chain between edges", term_cnt, 1);
      en_stage = 1; #0.2; en_stage = 0; #0.2;
      chk(term_cnt == 1, "R7 stage enable ignored by tc", term_cnt, 1);
      chk(count == MAXV, "R7 state unchanged during tc test", count, MAXV);
      step();
      preset(4'd14);
      set_ctl(1, 1, 1, 1, 4'd0);
      #0.5;
      chk(term_cnt == 0, "R6 tc low below max", term_cnt, 0);
   endtask

   task automatic t_mid_cycle();
      preset(4'd3);
      set_ctl(1, 0, 1, 1, 4'd9);
      #1;
      chk(count == 3, "R8 no change before edge (load)", count, 3);
      sync_clr_n = 0;
      #0.5;
      chk(count == 3, "R8 no change before edge (clear)", count, 3);
      sync_clr_n = 1;
      step();
      chk(count == 9, "R8 load taken at edge", count, 9);
   endtask

   task automatic t_mode_table();
      logic [W-1:0] starts [3] = '{4'd15, 4'd0, 4'd8};
      for (int s = 0; s < 3; s++) begin
         for (int m = 0; m < 16; m++) begin
            logic [W-1:0] e;
            preset(starts[s]);
            set_ctl(m[3], m[2], m[1], m[0], 4'd5);
            e = model(starts[s], m[3], m[2], m[1], m[0], 4'd5);
            step();
            chk(count == e, "R4 mode table row", count, e);
         end
      end
   endtask

   initial begin
      #(4 * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      t_count_wrap();
      t_load();
      t_clear_over_load();
      t_hold();
      t_term();
      t_mid_cycle();
      t_mode_table();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule